// File: doc/BRIEF.md
# Configurable GPIO Pin Bank

This block holds the register state of one bank of general-purpose pins, up to 32 of them. Each pin has a function field, a data bit and a pull-up enable bit, and all three sit behind a small word-addressed register bus. A pin set as an input copies its external level into its data bit. A pin set as an output drives the value written to its data bit. A pin set for interrupt use passes its sampled level to a per-pin interrupt request output, for an interrupt controller outside this block.

A data write is checked against the current data register. Output pins whose bit changes get their driven level updated, and each one raises a strobe for one cycle. Other pins keep their driven level.

A parameter selects a compact legacy variant. In that variant each pin has a single function bit: 0 makes the pin an output and 1 hands the pin to another function. The legacy variant does not sample pins and does not raise interrupts. The pad cells and the pull-up resistors are outside this block.

Top module: `pinbank`

## Requirements
- R1: While reset is high and in the cycle after it, the standard variant has every function field at 0 (all pins inputs). The data register, `pin_out`, `pin_oe`, `chg_strobe` and `irq_req` are all 0.
- R2: In the standard variant, pin n is set by the 2-bit field at bits [2n+1:2n] of the function register. 00 selects input, 01 output, 10 interrupt and 11 reserved. `pin_oe[n]` is 1 only for code 01.
- R3: For pins coded 00 or 10, the data bit takes the level of `pin_in` at each clock edge. A written value for such a pin is not kept.
- R4: One clock edge after `pin_in` changes, `irq_req[n]` shows that level for pins coded 10. It is 0 for pins with any other code.
- R5: A data write (offset 0x4) stores only the implemented pin bits. At the next edge, `pin_out` takes the new value only on output pins whose bit differs from the data register. Writes to the function register or the pull-up register never change `pin_out`.
- R6: In the cycle after a data write, `chg_strobe` has a 1 for each output pin whose bit changed. In every other cycle it is 0.
- R7: The function register is at offset 0x0, data at 0x4 and pull-up at 0x8. `rdata` is valid one cycle after `rd_en`, is 0 in any cycle that follows no read, and reads bits above the implemented fields as 0.
- R8: A read of any other offset returns 0. A write to any other offset changes no register and no output.
- R9: The pull-up register resets to the `PULL_RST` parameter masked to the implemented pins. It is writable, and `pull_en` shows its value.
- R10: In the legacy variant, each pin has one function bit at bit n, where 0 means output. That register resets to `CFG_RST_LEGACY` masked to the implemented pins. Data bits are never sampled from `pin_in`, and `irq_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset within the bank |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| pin_in | input | PIN_COUNT | Sampled external pin levels |
| pin_out | output | PIN_COUNT | Driven pin levels |
| pin_oe | output | PIN_COUNT | Output enable per pin |
| pull_en | output | PIN_COUNT | Pull-up enable per pin |
| irq_req | output | PIN_COUNT | Interrupt request level per pin |
| chg_strobe | output | PIN_COUNT | One-cycle strobe for changed output pins |

## Verification
The bench uses a 6-pin standard bank and a 10-pin legacy bank.

- **Data-value sweep with all pins as outputs.** Every one of the 64 data values is written with the upper bits set. This separates correct masking from leaking bits, and shows that the strobe tracks exactly the bit difference between consecutive writes.
- **Pin-level sweep with one pin of each code.** All 64 `pin_in` patterns are applied. This tells sampled pins from held pins and interrupt pins from the rest.
- **Offset sweeps.** Reads and writes across all 16 offsets separate the three mapped registers from the unmapped space.
- **Legacy-bank sequence.** The legacy bank is driven through a function-bit change. This shows that its inverted one-bit coding gates both the drive and the strobe.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  // function codes of a standard-variant pin field
  typedef enum logic [1:0] {
    PF_IN  = 2'b00,
    PF_OUT = 2'b01,
    PF_IRQ = 2'b10,
    PF_RSV = 2'b11
  } pin_fn_e;

  // byte offsets inside the bank window
  localparam int OFS_CFG = 'h0;
  localparam int OFS_DAT = 'h4;
  localparam int OFS_PUL = 'h8;

  // legacy coding: function bit value that selects output drive
  localparam logic LEG_OUT = 1'b0;

endpackage

// File: rtl/pinbank_decode.sv
module pinbank_decode
  import pinbank_pkg::*;
#(
  parameter int PIN_COUNT = 16,
  parameter bit LEGACY    = 1'b0,
  parameter int CFG_W     = 32
) (
  input  logic [CFG_W-1:0]     cfg,
  output logic [PIN_COUNT-1:0] oe,
  output logic [PIN_COUNT-1:0] smp,
  output logic [PIN_COUNT-1:0] irq_en
);

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_pin
    if (LEGACY) begin : g_leg
      assign oe[i]     = (cfg[i] == LEG_OUT);
      assign smp[i]    = 1'b0;
      assign irq_en[i] = 1'b0;
    end else begin : g_std
      pin_fn_e fn;
      assign fn        = pin_fn_e'(cfg[2*i +: 2]);
      assign oe[i]     = (fn == PF_OUT);
      assign smp[i]    = (fn == PF_IN) || (fn == PF_IRQ);
      assign irq_en[i] = (fn == PF_IRQ);
    end
  end

endmodule

// File: rtl/pinbank_data.sv
module pinbank_data #(
  parameter int PIN_COUNT = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 dat_we,
  input  logic [PIN_COUNT-1:0] wval,
  input  logic [PIN_COUNT-1:0] pin_in,
  input  logic [PIN_COUNT-1:0] oe,
  input  logic [PIN_COUNT-1:0] smp,
  input  logic [PIN_COUNT-1:0] irq_en,
  output logic [PIN_COUNT-1:0] dat_q,
  output logic [PIN_COUNT-1:0] drv_q,
  output logic [PIN_COUNT-1:0] chg_q,
  output logic [PIN_COUNT-1:0] irq_q
);

  logic [PIN_COUNT-1:0] diff;
  logic [PIN_COUNT-1:0] dat_nxt;

  // output pins whose written bit differs from the stored bit
  always_comb begin
    diff    = dat_we ? ((dat_q ^ wval) & oe) : '0;
    dat_nxt = dat_we ? wval : dat_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dat_q <= '0;
      drv_q <= '0;
      chg_q <= '0;
      irq_q <= '0;
    end else begin
      dat_q <= (dat_nxt & ~smp) | (pin_in & smp);
      drv_q <= (drv_q & ~diff) | (wval & diff);
      chg_q <= diff;
      irq_q <= pin_in & irq_en;
    end
  end

endmodule

// File: rtl/pinbank_rdmux.sv
module pinbank_rdmux
  import pinbank_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4,
  parameter int CFG_W     = 32,
  parameter int PIN_COUNT = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [CFG_W-1:0]     cfg,
  input  logic [PIN_COUNT-1:0] dat,
  input  logic [PIN_COUNT-1:0] pul,
  output logic [DATA_W-1:0]    rdata
);

  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(OFS_DAT);
  localparam logic [ADDR_W-1:0] A_PUL = ADDR_W'(OFS_PUL);

  logic [DATA_W-1:0] sel;

  always_comb begin
    unique case (addr)
      A_CFG:   sel = DATA_W'(cfg);
      A_DAT:   sel = DATA_W'(dat);
      A_PUL:   sel = DATA_W'(pul);
      default: sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel;
    else            rdata <= '0;
  end

endmodule

// File: rtl/pinbank.sv
module pinbank
  import pinbank_pkg::*;
#(
  parameter int          PIN_COUNT      = 16,
  parameter bit          LEGACY         = 1'b0,
  parameter int          DATA_W         = 32,
  parameter int          ADDR_W         = 4,
  parameter logic [31:0] PULL_RST       = 32'h0000_0000,
  parameter logic [31:0] CFG_RST_LEGACY = 32'h07FF_FFFF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic [PIN_COUNT-1:0] pin_in,
  output logic [PIN_COUNT-1:0] pin_out,
  output logic [PIN_COUNT-1:0] pin_oe,
  output logic [PIN_COUNT-1:0] pull_en,
  output logic [PIN_COUNT-1:0] irq_req,
  output logic [PIN_COUNT-1:0] chg_strobe
);

  // function register width: one bit per pin (legacy) or two
  localparam int CFG_W = LEGACY ? PIN_COUNT : 2 * PIN_COUNT;
  localparam logic [31:0] PIN_MASK =
    (PIN_COUNT >= 32) ? 32'hFFFF_FFFF : ((32'd1 << PIN_COUNT) - 32'd1);
  localparam logic [CFG_W-1:0] CFG_RST =
    LEGACY ? CFG_RST_LEGACY[CFG_W-1:0] : '0;
  localparam logic [PIN_COUNT-1:0] PUL_RST = PULL_RST[PIN_COUNT-1:0] & PIN_MASK[PIN_COUNT-1:0];

  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(OFS_DAT);
  localparam logic [ADDR_W-1:0] A_PUL = ADDR_W'(OFS_PUL);

  logic [CFG_W-1:0]     cfg_q;
  logic [PIN_COUNT-1:0] pul_q;
  logic [PIN_COUNT-1:0] oe;
  logic [PIN_COUNT-1:0] smp;
  logic [PIN_COUNT-1:0] irq_en;
  logic [PIN_COUNT-1:0] dat_q;
  logic                 cfg_we;
  logic                 dat_we;
  logic                 pul_we;

  assign cfg_we = wr_en && (addr == A_CFG);
  assign dat_we = wr_en && (addr == A_DAT);
  assign pul_we = wr_en && (addr == A_PUL);

  if (CFG_W < DATA_W) begin : g_spare
    logic unused_wbits;
    assign unused_wbits = ^wdata[DATA_W-1:CFG_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_RST;
      pul_q <= PUL_RST;
    end else begin
      if (cfg_we) cfg_q <= wdata[CFG_W-1:0];
      if (pul_we) pul_q <= wdata[PIN_COUNT-1:0];
    end
  end

  pinbank_decode #(
    .PIN_COUNT (PIN_COUNT),
    .LEGACY    (LEGACY),
    .CFG_W     (CFG_W)
  ) u_decode (
    .cfg    (cfg_q),
    .oe     (oe),
    .smp    (smp),
    .irq_en (irq_en)
  );

  pinbank_data #(
    .PIN_COUNT (PIN_COUNT)
  ) u_data (
    .clk    (clk),
    .rst    (rst),
    .dat_we (dat_we),
    .wval   (wdata[PIN_COUNT-1:0]),
    .pin_in (pin_in),
    .oe     (oe),
    .smp    (smp),
    .irq_en (irq_en),
    .dat_q  (dat_q),
    .drv_q  (pin_out),
    .chg_q  (chg_strobe),
    .irq_q  (irq_req)
  );

  pinbank_rdmux #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .CFG_W     (CFG_W),
    .PIN_COUNT (PIN_COUNT)
  ) u_rdmux (
    .clk   (clk),
    .rst   (rst),
    .rd_en (rd_en),
    .addr  (addr),
    .cfg   (cfg_q),
    .dat   (dat_q),
    .pul   (pul_q),
    .rdata (rdata)
  );

  assign pin_oe  = oe;
  assign pull_en = pul_q;

endmodule

// File: rtl/pinbank_chk.sv
module pinbank_chk
  import pinbank_pkg::*;
#(
  parameter int PIN_COUNT = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    rdata,
  input logic [PIN_COUNT-1:0] pin_out,
  input logic [PIN_COUNT-1:0] pin_oe,
  input logic [PIN_COUNT-1:0] chg_strobe
);

  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(OFS_DAT);
  localparam logic [ADDR_W-1:0] A_PUL = ADDR_W'(OFS_PUL);

  logic dat_wr;
  logic unmapped;
  assign dat_wr   = wr_en && (addr == A_DAT);
  assign unmapped = (addr != A_CFG) && (addr != A_DAT) && (addr != A_PUL);

  // R5
  drive_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(dat_wr) |-> $stable(pin_out));

  // R6
  strobe_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    (chg_strobe != '0) |-> $past(dat_wr));

  // R6
  strobe_output_only_chk: assert property (@(posedge clk) disable iff (rst)
    (chg_strobe & ~pin_oe) == '0);

  // R8
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && unmapped) |-> (rdata == '0));

  // R7
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rd_en) |-> (rdata == '0));

endmodule

bind pinbank pinbank_chk #(
  .PIN_COUNT (PIN_COUNT),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .rd_en      (rd_en),
  .addr       (addr),
  .rdata      (rdata),
  .pin_out    (pin_out),
  .pin_oe     (pin_oe),
  .chg_strobe (chg_strobe)
);

// File: tb/pinbank_test.sv
module pinbank_test;

  localparam int SP = 6;
  localparam int LP = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        s_wr = 1'b0, s_rd = 1'b0, l_wr = 1'b0, l_rd = 1'b0;
  logic [31:0] s_rdata, l_rdata;
  logic [SP-1:0] s_pin = '0, s_out, s_oe, s_pul, s_irq, s_chg;
  logic [LP-1:0] l_pin = '0, l_out, l_oe, l_pul, l_irq, l_chg;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  pinbank #(.PIN_COUNT(SP), .LEGACY(1'b0), .PULL_RST(32'h0000_F0F0)) uut (
    .clk(clk), .rst(rst), .wr_en(s_wr), .rd_en(s_rd), .addr(addr), .wdata(wdata),
    .rdata(s_rdata), .pin_in(s_pin), .pin_out(s_out), .pin_oe(s_oe),
    .pull_en(s_pul), .irq_req(s_irq), .chg_strobe(s_chg));

  pinbank #(.PIN_COUNT(LP), .LEGACY(1'b1), .PULL_RST(32'h0000_F00F),
            .CFG_RST_LEGACY(32'h07FF_FFFF)) uut_leg (
    .clk(clk), .rst(rst), .wr_en(l_wr), .rd_en(l_rd), .addr(addr), .wdata(wdata),
    .rdata(l_rdata), .pin_in(l_pin), .pin_out(l_out), .pin_oe(l_oe),
    .pull_en(l_pul), .irq_req(l_irq), .chg_strobe(l_chg));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input bit leg, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (leg) l_wr = 1'b1; else s_wr = 1'b1;
    @(negedge clk);
    s_wr = 1'b0; l_wr = 1'b0;
  endtask

  task automatic bus_rd(input bit leg, input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    if (leg) l_rd = 1'b1; else s_rd = 1'b1;
    @(negedge clk);
    d = leg ? l_rdata : s_rdata;
    s_rd = 1'b0; l_rd = 1'b0;
  endtask

  // standard-bank model state
  logic [5:0] m_dat, m_drv, m_oe, m_smp;

  task automatic model_wr(input logic [31:0] w);
    logic [5:0] diff;
    diff  = (m_dat ^ w[5:0]) & m_oe;
    bus_wr(1'b0, 4'h4, w);
    m_drv = (m_drv & ~diff) | (w[5:0] & diff);
    m_dat = (w[5:0] & ~m_smp) | (s_pin & m_smp);
    chk("R5 drive after data write", 32'(s_out), 32'(m_drv));
    chk("R6 change strobe", 32'(s_chg), 32'(diff));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [5:0]  prev;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R9 pull reset
    chk("R1 pin_out reset", 32'(s_out), 0);
    chk("R1 pin_oe reset", 32'(s_oe), 0);
    chk("R1 strobe reset", 32'(s_chg), 0);
    chk("R1 irq reset", 32'(s_irq), 0);
    chk("R9 pull reset", 32'(s_pul), 32'h30);
    bus_rd(1'b0, 4'h0, rd); chk("R1 cfg reads 0", rd, 0);
    bus_rd(1'b0, 4'h4, rd); chk("R1 data reads 0", rd, 0);

    // R8 unmapped offsets
    for (int a = 0; a < 16; a++) begin
      if (a != 0 && a != 4 && a != 8) begin
        bus_rd(1'b0, 4'(a), rd); chk("R8 unmapped read", rd, 0);
        bus_wr(1'b0, 4'(a), 32'hFFFF_FFFF);
        chk("R8 unmapped write no strobe", 32'(s_chg), 0);
      end
    end
    chk("R8 unmapped write oe", 32'(s_oe), 0);
    bus_rd(1'b0, 4'h0, rd); chk("R8 cfg untouched", rd, 0);
    bus_rd(1'b0, 4'h8, rd); chk("R8 pull untouched", rd, 32'h30);

    // R2 / R7 all outputs, upper bits masked
    bus_wr(1'b0, 4'h0, 32'hFFFF_F555);
    bus_rd(1'b0, 4'h0, rd); chk("R7 cfg read masked", rd, 32'h555);
    chk("R2 all outputs oe", 32'(s_oe), 32'h3F);
    chk("R5 cfg write no drive", 32'(s_out), 0);

    m_dat = '0; m_drv = '0; m_oe = 6'h3F; m_smp = '0;
    prev = '0;
    for (int v = 0; v < 64; v++) begin
      model_wr(32'hFFFF_FFC0 | 32'(v));
      chk("R5 pin_out follows data", 32'(s_out), 32'(v));
      chk("R6 strobe is bit diff", 32'(s_chg), 32'(prev ^ 6'(v)));
      @(negedge clk);
      chk("R6 strobe one cycle", 32'(s_chg), 0);
      prev = 6'(v);
    end
    bus_rd(1'b0, 4'h4, rd); chk("R7 data read masked", rd, 32'h3F);

    // mixed: pins0,1 in; 2,3 out; 4 irq; 5 reserved
    bus_wr(1'b0, 4'h0, 32'h0000_0E50);
    m_oe = 6'h0C; m_smp = 6'h13;
    @(negedge clk);
    m_dat = (m_dat & ~m_smp) | (s_pin & m_smp);
    chk("R2 mixed oe", 32'(s_oe), 32'h0C);
    chk("R5 mixed cfg no drive", 32'(s_out), 32'h3F);
    model_wr(32'h0000_000B);
    chk("R2 reserved pin not driven", 32'(s_out[5]), 1);

    for (int v = 0; v < 64; v++) begin
      @(negedge clk); s_pin = 6'(v);
      @(negedge clk);
      m_dat = (m_dat & ~m_smp) | (6'(v) & m_smp);
      chk("R4 irq only on code 10", 32'(s_irq), 32'(v & 6'h10));
      bus_rd(1'b0, 4'h4, rd);
      chk("R3 input data sampled", rd, 32'(m_dat));
      chk("R3 inputs not driven", 32'(s_out), 32'(m_drv));
    end
    s_pin = 6'h05;
    @(negedge clk);
    model_wr(32'h0000_003F);
    bus_rd(1'b0, 4'h4, rd);
    chk("R3 write ignored on inputs", rd, 32'h2D);

    // R9 pull register
    bus_wr(1'b0, 4'h8, 32'hFFFF_FFC5);
    chk("R9 pull_en written", 32'(s_pul), 32'h05);
    bus_rd(1'b0, 4'h8, rd); chk("R9 pull read", rd, 32'h05);
    chk("R5 pull write no drive", 32'(s_out), 32'(m_drv));

    // all inputs: data writes do not drive
    bus_wr(1'b0, 4'h0, 32'h0);
    m_oe = '0; m_smp = 6'h3F;
    model_wr(32'h0000_0000);
    chk("R6 no strobe on inputs", 32'(s_chg), 0);

    // R10 legacy bank
    bus_rd(1'b1, 4'h0, rd); chk("R10 legacy cfg reset", rd, 32'h3FF);
    chk("R10 legacy oe reset", 32'(l_oe), 0);
    chk("R9 legacy pull reset", 32'(l_pul), 32'h00F);
    bus_wr(1'b1, 4'h0, 32'h0);
    chk("R10 legacy 0 is output", 32'(l_oe), 32'h3FF);
    bus_wr(1'b1, 4'h4, 32'h0000_02A5);
    chk("R10 legacy drive", 32'(l_out), 32'h2A5);
    chk("R10 legacy strobe", 32'(l_chg), 32'h2A5);
    l_pin = 10'h3FF;
    @(negedge clk); @(negedge clk);
    chk("R10 legacy irq stays 0", 32'(l_irq), 0);
    bus_rd(1'b1, 4'h4, rd); chk("R10 legacy no sampling", rd, 32'h2A5);
    bus_wr(1'b1, 4'h0, 32'h0000_00F0);
    chk("R10 legacy function pins oe", 32'(l_oe), 32'h30F);
    bus_wr(1'b1, 4'h4, 32'h0);
    chk("R10 legacy strobe gated", 32'(l_chg), 32'h205);
    chk("R10 legacy drive gated", 32'(l_out), 32'h0A0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule